// File: doc/BRIEF.md
# Prescaled Real-Time Counter with Alarm

The block turns a slow input tick into a time base and counts time-base ticks in a wide free-running counter. The slow tick arrives as a one-cycle pulse on `tick_in`, synchronous to the fast system clock. A down-counting divider reloads from a programmable value and emits one time-base tick each time it passes through zero. Each time-base tick advances the main counter by one. The counter is compared against an alarm value.

Three sticky event flags report activity: a per-tick flag, an alarm flag and a wrap flag. Each flag has its own enable, and the enabled flags are ORed into one interrupt line. A small write-only register port loads the divider reload value, the counter and the alarm. The same port sets the enables and clears the flags. The reset defaults give one time-base tick per second from a 32.768 kHz input tick.

Top module: `rtc_timebase`

## Requirements
- R1: After reset the counter reads 0, all flags read 0, all enables are 0 and `irq_o` is 0. The divider reload value and the divider itself both start at 32767.
- R2: With the reset defaults, input ticks 1 to 32767 leave the counter unchanged. The 32768th input tick raises it to 1.
- R3: With reload value R, the counter advances by exactly one on every (R+1)th input tick. It never changes in a cycle without `tick_in`.
- R4: A write to the reload register (address 0, `wr_data[19:0]`) or to the counter register (address 1) is held pending until the next input tick. That tick loads a written counter value, restarts the divider at the reload value and produces no time-base tick. The first time-base tick after the restart comes on the (R+1)th input tick after that one.
- R5: A time-base tick taken while the counter is all ones returns the counter to 0 and sets the wrap flag (`flags_o[2]`).
- R6: The alarm flag (`flags_o[1]`) is set when a time-base tick steps the counter onto the value written to the alarm register (address 2).
- R7: Every time-base tick sets the tick flag (`flags_o[0]`).
- R8: The flags are sticky. A write to the control register (address 3) with `wr_data[4]`, `[5]` or `[6]` at 1 clears the tick, alarm or wrap flag respectively. A new event in the same cycle as a clear wins.
- R9: A control write stores the enables from `wr_data[0]` (tick), `wr_data[1]` (alarm) and `wr_data[2]` (wrap). `irq_o` is 1 exactly when some flag and its enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | One-cycle pulse per slow input clock period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 reload, 1 counter, 2 alarm, 3 control |
| wr_data | input | 32 | Write data |
| count_o | output | 32 | Current counter value |
| flags_o | output | 3 | Sticky flags: bit 0 tick, bit 1 alarm, bit 2 wrap |
| irq_o | output | 1 | OR of the enabled flags |

## Verification
The divider is first run for a full default period. This separates an off-by-one reload (a tick one input early or late) from a correct one. A short reload of 3 is then written. The first period after the write (five input ticks) is checked separately from the steady periods (four ticks), which shows the restart tick is spent on the reload. A counter load next to all ones drives the wrap. A small alarm value is approached one period at a time, so the alarm flag must rise on the matching step and not before. The enable and clear writes are applied while flags are set, which separates gating from clearing.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   typedef enum logic [1:0] {
      REG_RELOAD = 2'd0,
      REG_COUNT  = 2'd1,
      REG_ALARM  = 2'd2,
      REG_CTRL   = 2'd3
   } rtc_reg_e;

   localparam int NUM_FLAGS = 3;
   localparam int FLAG_TICK = 0;
   localparam int FLAG_ALM  = 1;
   localparam int FLAG_WRAP = 2;
   localparam int CLR_LSB   = 4;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int PRE_W       = 20,
   parameter int PRE_DEFAULT = 32767
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_in,
   input  logic             restart,
   input  logic [PRE_W-1:0] reload,
   output logic             base_tick
);
   localparam logic [PRE_W-1:0] DIV_INIT = PRE_W'(PRE_DEFAULT);

   logic [PRE_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= DIV_INIT;
      end else if (tick_in) begin
         if (restart || div_q == '0) div_q <= reload;
         else                        div_q <= div_q - 1'b1;
      end
   end

   assign base_tick = tick_in && !restart && (div_q == '0);

   // R3: divider state only moves on an input tick
   a_r3_div_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_in |=> $stable(div_q));
   // R4: a restart tick reloads the divider
   a_r4_restart_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_in && restart) |=> div_q == $past(reload));
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] alarm,
   output logic [CNT_W-1:0] count_o,
   output logic             wrap_evt,
   output logic             match_evt
);
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] count_inc;

   assign count_inc = count_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count_q <= '0;
      else if (load) count_q <= load_val;
      else if (step) count_q <= count_inc;
   end

   assign wrap_evt  = step && !load && (count_q == '1);
   assign match_evt = step && !load && (count_inc == alarm);
   assign count_o   = count_q;

   // R5: all-ones plus one gives zero
   a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && count_q == '1) |=> count_q == '0);
   // R3: counter is frozen without step or load
   a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(count_q));
endmodule

// File: rtl/rtc_flags.sv
module rtc_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_evt,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] en,
   output logic [N-1:0] flags_o,
   output logic         irq_o
);
   logic [N-1:0] flag_q;

   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          flag_q[i] <= 1'b0;
         else if (set_evt[i]) flag_q[i] <= 1'b1;
         else if (clr[i])     flag_q[i] <= 1'b0;
      end

      // R8: flag holds until a clear is requested
      a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q[i] && !clr[i]) |=> flag_q[i]);
      // R8: event wins over a simultaneous clear
      a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set_evt[i] |=> flag_q[i]);
   end

   assign flags_o = flag_q;
   assign irq_o   = |(flag_q & en);

   // R9: no enables means no interrupt
   a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> !irq_o);
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
   import rtc_pkg::*;
#(
   parameter int PRE_W       = 20,
   parameter int CNT_W       = 32,
   parameter int PRE_DEFAULT = 32767
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_in,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] count_o,
   output logic [2:0]       flags_o,
   output logic             irq_o
);
   localparam logic [PRE_W-1:0] RELOAD_INIT = PRE_W'(PRE_DEFAULT);

   if (PRE_W < 2 || CNT_W < PRE_W || CNT_W < CLR_LSB + NUM_FLAGS) begin : g_bad_width
      $error("rtc_timebase: unsupported width parameters");
   end
   if (PRE_DEFAULT < 0 || PRE_DEFAULT >= (2 ** PRE_W)) begin : g_bad_default
      $error("rtc_timebase: default reload does not fit the divider");
   end

   rtc_reg_e         sel;
   logic [PRE_W-1:0] reload_q;
   logic [CNT_W-1:0] alarm_q;
   logic [CNT_W-1:0] stage_q;
   logic             stage_pend_q;
   logic             restart_pend_q;
   logic [NUM_FLAGS-1:0] en_q;
   logic [NUM_FLAGS-1:0] clr;
   logic [NUM_FLAGS-1:0] evt;
   logic             base_tick;
   logic             wrap_evt;
   logic             match_evt;
   logic             wr_reload, wr_count, wr_alarm, wr_ctrl;

   assign sel       = rtc_reg_e'(wr_addr);
   assign wr_reload = wr_en && sel == REG_RELOAD;
   assign wr_count  = wr_en && sel == REG_COUNT;
   assign wr_alarm  = wr_en && sel == REG_ALARM;
   assign wr_ctrl   = wr_en && sel == REG_CTRL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q       <= RELOAD_INIT;
         alarm_q        <= '0;
         stage_q        <= '0;
         stage_pend_q   <= 1'b0;
         restart_pend_q <= 1'b0;
         en_q           <= '0;
      end else begin
         if (wr_reload) reload_q <= wr_data[PRE_W-1:0];
         if (wr_alarm)  alarm_q  <= wr_data;
         if (wr_ctrl)   en_q     <= wr_data[NUM_FLAGS-1:0];
         if (wr_count) begin
            stage_q      <= wr_data;
            stage_pend_q <= 1'b1;
         end else if (tick_in) begin
            stage_pend_q <= 1'b0;
         end
         if (wr_reload || wr_count) restart_pend_q <= 1'b1;
         else if (tick_in)          restart_pend_q <= 1'b0;
      end
   end

   assign clr = wr_ctrl ? wr_data[CLR_LSB +: NUM_FLAGS] : '0;

   rtc_prescaler #(.PRE_W(PRE_W), .PRE_DEFAULT(PRE_DEFAULT)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_in   (tick_in),
      .restart   (restart_pend_q),
      .reload    (reload_q),
      .base_tick (base_tick)
   );

   rtc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (base_tick),
      .load      (tick_in && stage_pend_q),
      .load_val  (stage_q),
      .alarm     (alarm_q),
      .count_o   (count_o),
      .wrap_evt  (wrap_evt),
      .match_evt (match_evt)
   );

   always_comb begin
      evt            = '0;
      evt[FLAG_TICK] = base_tick;
      evt[FLAG_ALM]  = match_evt;
      evt[FLAG_WRAP] = wrap_evt;
   end

   rtc_flags #(.N(NUM_FLAGS)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (evt),
      .clr     (clr),
      .en      (en_q),
      .flags_o (flags_o),
      .irq_o   (irq_o)
   );

   // R4: a pending counter write lands on the next input tick
   a_r4_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_in && stage_pend_q) |=> count_o == $past(stage_q));
   // R4: a restart tick never advances the time base
   a_r4_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_in && restart_pend_q && !stage_pend_q) |=> $stable(count_o));
endmodule

// File: tb/rtc_timebase_test.sv
`timescale 1ns/1ps
module rtc_timebase_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_in = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [31:0] wr_data = '0;
   logic [31:0] count_o;
   logic [2:0]  flags_o;
   logic        irq_o;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   rtc_timebase uut (
      .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .count_o(count_o),
      .flags_o(flags_o), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick_in = 1'b1;
         @(negedge clk) tick_in = 1'b0;
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_reset;
      check("R1 count", count_o, 0);
      check("R1 flags", {29'd0, flags_o}, 0);
      check("R1 irq", {31'd0, irq_o}, 0);
   endtask

   task automatic t_default;
      ticks(32767);
      check("R2 count before period", count_o, 0);
      check("R2 tick flag before period", {31'd0, flags_o[0]}, 0);
      ticks(1);
      check("R2 count after period", count_o, 1);
      check("R7 tick flag", {31'd0, flags_o[0]}, 1);
   endtask

   task automatic t_hold;
      repeat (20) @(negedge clk);
      check("R3 idle hold", count_o, 1);
   endtask

   task automatic t_reload;
      wr(2'd0, 32'd3);
      ticks(4);
      check("R4 restart tick spent", count_o, 1);
      check("R8 tick flag sticky", {31'd0, flags_o[0]}, 1);
      ticks(1);
      check("R4 first period", count_o, 2);
      ticks(3);
      check("R3 mid period", count_o, 2);
      ticks(1);
      check("R3 steady period", count_o, 3);
   endtask

   task automatic t_clear;
      wr(2'd3, 32'h70);
      check("R8 clear all", {29'd0, flags_o}, 0);
      ticks(4);
      check("R7 tick again", {29'd0, flags_o}, 3'b001);
      check("R9 masked", {31'd0, irq_o}, 0);
      wr(2'd3, 32'h1);
      check("R9 enabled", {31'd0, irq_o}, 1);
      wr(2'd3, 32'h0);
      check("R9 disabled again", {31'd0, irq_o}, 0);
      check("R8 enable write keeps flag", {29'd0, flags_o}, 3'b001);
   endtask

   task automatic t_wrap;
      wr(2'd1, 32'hFFFF_FFFE);
      ticks(1);
      check("R4 counter load", count_o, 32'hFFFF_FFFE);
      ticks(4);
      check("R5 all ones", count_o, 32'hFFFF_FFFF);
      check("R5 no wrap yet", {31'd0, flags_o[2]}, 0);
      ticks(4);
      check("R5 wrapped", count_o, 0);
      check("R5 wrap flag", {31'd0, flags_o[2]}, 1);
   endtask

   task automatic t_alarm;
      wr(2'd2, 32'd2);
      wr(2'd3, 32'h72);
      check("R8 cleared before alarm", {29'd0, flags_o}, 0);
      ticks(4);
      check("R6 step to 1", count_o, 1);
      check("R6 no alarm early", {31'd0, flags_o[1]}, 0);
      check("R9 no irq early", {31'd0, irq_o}, 0);
      ticks(4);
      check("R6 step to 2", count_o, 2);
      check("R6 alarm flag", {31'd0, flags_o[1]}, 1);
      check("R9 alarm irq", {31'd0, irq_o}, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_default();
      t_hold();
      t_reload();
      t_clear();
      t_wrap();
      t_alarm();
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule